// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by running a 7-bit counter downward at a slow, programmable rate. Software must reload the counter inside an allowed window. A reload that comes too late lets the counter fall past its lower threshold. A reload that comes too early, while the counter is still above a programmed limit, is caught at once. Either case produces a one-cycle system reset request, but only once the watchdog has been armed. The reset controller that acts on that request is outside the block.

The counter steps once per tick. A fixed base divider (4096 in the default build) produces the base ticks, and a further power-of-two stage selected by software divides them again. One count before the reset threshold, the block sets a warning flag. If software has enabled it, that flag drives an interrupt, so software gets a last chance to reload the counter.

Software reaches the block through three 32-bit registers on a simple single-cycle bus with per-byte write lanes, so both halfword and word accesses work. The registers are control, configuration and status. Read data is registered.

Top module: `wdw_top`

## Requirements
- R1: Register offsets and reset values:
  - 0x0 is control, and it resets to 0x7F.
  - 0x4 is configuration, and it resets to 0x7F.
  - 0x8 is status, and it resets to 0x0.
  - A read of any other word offset returns 0.
- R2: Write lanes and unused bits:
  - Each bit of `bus_be` enables one byte lane of a write, with bit 0 for bits 7:0 and bit 1 for bits 15:8.
  - Lanes that are not enabled leave their bits unchanged.
  - Bits with no defined field always read 0, and writes to them are ignored.
- R3: Counter loading and stepping:
  - A write to control with lane 0 enabled loads control bits 6:0 into the counter.
  - Otherwise the counter decrements by one on each tick, and it wraps from 0x00 to 0x7F.
  - The counter keeps running while the watchdog is unarmed.
- R4: Configuration bits 8:7 hold the divide select `p`, and the tick period is `BASE_DIV * 2^p` clock cycles.
- R5: Arming bit (control bit 7):
  - Writing 1 to control bit 7 arms the watchdog.
  - Writing 0 has no effect.
  - Only `rst` clears the bit.
- R6: When the watchdog is armed, a tick that arrives while the counter holds 0x40 raises `wdog_rst_req` for exactly one cycle after that clock edge.
- R7: Loads inside and outside the window:
  - A counter load while the watchdog is armed and the counter is greater than the window value (configuration bits 6:0) raises `wdog_rst_req` for one cycle.
  - A load while the counter is at or below the window value raises no request.
- R8: While the watchdog is unarmed, `wdog_rst_req` stays 0.
- R9: Warning flag (status bit 0):
  - The flag is set on the edge where a tick moves the counter from 0x41 to 0x40, whether or not the interrupt is enabled.
  - A status write with lane 0 enabled and bit 0 equal to 0 clears the flag.
  - Writing 1 leaves the flag as it is.
- R10: Warning interrupt:
  - `early_irq` equals the warning flag ANDed with the interrupt enable (configuration bit 9).
  - The interrupt enable is set by writing 1 to that bit, and only `rst` clears it.
- R11: For a read request on edge N, `bus_rdata` shows the addressed register after edge N and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdog_rst_req | output | 1 | One-cycle system reset request |
| early_irq | output | 1 | Warning interrupt |

## Verification
The bench builds the block with `BASE_DIV = 4` and `ADDR_W = 4`, so a tick occurs every four cycles with divide select 0 and every 32 cycles with divide select 3. At that rate a full pass through the 128 counter values takes a few hundred cycles. That brings the wrap, the 0x41 to 0x40 warning step, the 0x40 to 0x3F reset step and both sides of the window within a short run. Because exactly one tick falls in any four consecutive edges at divide select 0, the bench can predict exact counter values after a load without knowing the tick phase. It measures the tick period as the distance from the warning interrupt to the reset request.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int CNT_W = 7;
  localparam int PSC_W = 2;
  localparam int DATA_W = 32;
  localparam int LANES = DATA_W / 8;

  localparam logic [CNT_W-1:0] CNT_INIT = '1;
  localparam logic [CNT_W-1:0] CNT_WARN = 7'h41;
  localparam logic [CNT_W-1:0] CNT_LAST = 7'h40;

  // control bit positions
  localparam int CTRL_ARM_BIT = 7;
  // configuration bit positions
  localparam int CFG_PSC_LO  = 7;
  localparam int CFG_IRQ_BIT = 9;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             irq_en;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wdw_prescaler.sv
module wdw_prescaler #(
  parameter int BASE_DIV = 4096,
  parameter int EXT_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [wdw_pkg::PSC_W-1:0] psc_i,
  output logic                     tick_o
);
  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [BW-1:0] BASE_TOP = BW'(BASE_DIV - 1);

  logic [BW-1:0]    base_q;
  logic [EXT_W-1:0] ext_q;
  logic [EXT_W-1:0] ext_mask;
  logic             base_wrap;
  logic             tick_q;

  assign base_wrap = (base_q == BASE_TOP);
  assign ext_mask  = ~({EXT_W{1'b1}} << psc_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ext_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      base_q <= base_wrap ? '0 : base_q + 1'b1;
      if (base_wrap)
        ext_q <= ext_q + 1'b1;
      tick_q <= base_wrap && ((ext_q & ext_mask) == ext_mask);
    end
  end

  assign tick_o = tick_q;

  // ticks never come on adjacent cycles (period at least BASE_DIV >= 2)
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
  import wdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             arm_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             warn_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             step;
  logic             too_early;
  logic             too_late;

  assign step      = tick_i && !load_i;
  assign too_early = load_i && (cnt_q > win_i);
  assign too_late  = step && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_INIT;
      req_q <= 1'b0;
    end else begin
      req_q <= arm_i && (too_early || too_late);
      if (load_i)
        cnt_q <= load_val_i;
      else if (tick_i)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign warn_o    = step && (cnt_q == CNT_WARN);
  assign rst_req_o = req_q;

  assert_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == $past(load_val_i));
  assert_rst_gated_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(arm_i));
endmodule

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              warn_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output cfg_t              cfg_o,
  output logic              arm_o,
  output logic              irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  reg_sel_e          rsel;
  logic              wr_ctrl, wr_cfg, wr_stat;
  logic              arm_q, flag_q;
  cfg_t              cfg_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_bits;

  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    if (word == WORD_W'(0))      rsel = SEL_CTRL;
    else if (word == WORD_W'(1)) rsel = SEL_CFG;
    else if (word == WORD_W'(2)) rsel = SEL_STAT;
    else                         rsel = SEL_NONE;
  end

  assign wr_ctrl = sel_i && wr_i && (rsel == SEL_CTRL);
  assign wr_cfg  = sel_i && wr_i && (rsel == SEL_CFG);
  assign wr_stat = sel_i && wr_i && (rsel == SEL_STAT);

  assign load_o     = wr_ctrl && be_i[0];
  assign load_val_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q       <= 1'b0;
      cfg_q.win   <= CNT_INIT;
      cfg_q.psc   <= '0;
      cfg_q.irq_en <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      if (wr_ctrl && be_i[0] && wdata_i[CTRL_ARM_BIT])
        arm_q <= 1'b1;
      if (wr_cfg && be_i[0]) begin
        cfg_q.win    <= wdata_i[CNT_W-1:0];
        cfg_q.psc[0] <= wdata_i[CFG_PSC_LO];
      end
      if (wr_cfg && be_i[1]) begin
        cfg_q.psc[1] <= wdata_i[CFG_PSC_LO+1];
        if (wdata_i[CFG_IRQ_BIT])
          cfg_q.irq_en <= 1'b1;
      end
      if (warn_i)
        flag_q <= 1'b1;
      else if (wr_stat && be_i[0] && !wdata_i[0])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rsel)
      SEL_CTRL: begin
        rd_mux[CNT_W-1:0]      = cnt_i;
        rd_mux[CTRL_ARM_BIT]   = arm_q;
      end
      SEL_CFG: begin
        rd_mux[CNT_W-1:0]                    = cfg_q.win;
        rd_mux[CFG_PSC_LO +: PSC_W]          = cfg_q.psc;
        rd_mux[CFG_IRQ_BIT]                  = cfg_q.irq_en;
      end
      SEL_STAT: rd_mux[0] = flag_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (sel_i && !wr_i)
      rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign cfg_o   = cfg_q;
  assign arm_o   = arm_q;
  assign irq_o   = flag_q && cfg_q.irq_en;

  assign unused_bits = ^{addr_i[1:0], be_i[LANES-1:2], wdata_i[DATA_W-1:CFG_IRQ_BIT+1]};

  assert_arm_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    arm_q |=> arm_q);
  assert_irqen_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_q.irq_en |=> cfg_q.irq_en);
  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(warn_i));
  assert_flag_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_stat) |=> flag_q);
endmodule

// File: rtl/wdw_top.sv
module wdw_top #(
  parameter int BASE_DIV = 4096,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdog_rst_req,
  output logic              early_irq
);
  import wdw_pkg::*;

  logic             tick;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             warn;
  logic             arm;
  cfg_t             cfg;

  wdw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (bus_sel),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .be_i       (bus_be),
    .wdata_i    (bus_wdata),
    .cnt_i      (cnt),
    .warn_i     (warn),
    .rdata_o    (bus_rdata),
    .load_o     (load),
    .load_val_o (load_val),
    .cfg_o      (cfg),
    .arm_o      (arm),
    .irq_o      (early_irq)
  );

  wdw_prescaler #(.BASE_DIV(BASE_DIV), .EXT_W(3)) u_psc (
    .clk    (clk),
    .rst    (rst),
    .psc_i  (cfg.psc),
    .tick_o (tick)
  );

  wdw_counter u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .load_i     (load),
    .load_val_i (load_val),
    .win_i      (cfg.win),
    .arm_i      (arm),
    .cnt_o      (cnt),
    .warn_o     (warn),
    .rst_req_o  (wdog_rst_req)
  );
endmodule

// File: tb/sim_wdw_top.sv
`timescale 1ns/1ps
module sim_wdw_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_rst_req;
  logic        early_irq;

  int checks = 0;
  int fails = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  wdw_top #(.BASE_DIV(4), .ADDR_W(4)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdog_rst_req(wdog_rst_req), .early_irq(early_irq)
  );

  always @(posedge clk) if (!rst && wdog_rst_req) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rst_req idle", 32'(wdog_rst_req), 0);
    chk("R10 irq idle", 32'(early_irq), 0);
    rd(4'h0, d); chk("R1 ctrl reset", d, 32'h7F);
    rd(4'h4, d); chk("R1 cfg reset", d, 32'h7F);
    rd(4'hC, d); chk("R1 unmapped read", d, 0);
    rd(4'h8, d); chk("R1 status reset", d, 0);
    // R11: request a read of cfg, data still old before the edge
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4;
    #1 chk("R11 data before edge", bus_rdata, 0);
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R11 data after edge", bus_rdata, 32'h7F);
    repeat (3) @(negedge clk);
    chk("R11 data held", bus_rdata, 32'h7F);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FC05, 4'hF);
    rd(4'h4, d); chk("R2 reserved cfg bits", d, 32'h05);
    wr(4'h4, 32'h0000_03FF, 4'h1);
    rd(4'h4, d); chk("R2 lane0 only", d, 32'hFF);
    wr(4'h4, 32'h0000_007F, 4'h3);
    rd(4'h4, d); chk("R2 halfword write", d, 32'h7F);
    wr(4'h0, 32'hFFFF_FFFF, 4'hC);
    rd(4'h0, d); chk("R2 upper lanes ignored", d & 32'hFFFF_FF80, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(4'h0, 32'h25, 4'h1);
    repeat (3) @(negedge clk);
    rd(4'h0, d); chk("R3 one step", d, 32'h24);
    wr(4'h0, 32'h00, 4'h1);
    repeat (3) @(negedge clk);
    rd(4'h0, d); chk("R3 wrap", d, 32'h7F);
  endtask

  task automatic t_flag;
    logic [31:0] d;
    int p0;
    p0 = pulses;
    wr(4'h0, 32'h43, 4'h1);
    repeat (20) @(negedge clk);
    chk("R8 no request unarmed", 32'(pulses - p0), 0);
    rd(4'h8, d); chk("R9 flag set", d, 1);
    chk("R10 irq masked", 32'(early_irq), 0);
    wr(4'h8, 32'h1, 4'h1);
    rd(4'h8, d); chk("R9 write 1 keeps", d, 1);
    wr(4'h8, 32'h0, 4'h1);
    rd(4'h8, d); chk("R9 write 0 clears", d, 0);
  endtask

  task automatic t_arm;
    logic [31:0] d;
    int p0;
    p0 = pulses;
    wr(4'h0, 32'hFF, 4'h1);
    rd(4'h0, d); chk("R5 armed", d & 32'h80, 32'h80);
    wr(4'h0, 32'h7F, 4'h1);
    rd(4'h0, d); chk("R5 write 0 ignored", d & 32'h80, 32'h80);
    chk("R7 reload in window", 32'(pulses - p0), 0);
  endtask

  task automatic t_window;
    int p0;
    wr(4'h4, 32'h50, 4'h1);
    p0 = pulses;
    wr(4'h0, 32'h7F, 4'h1);
    repeat (2) @(negedge clk);
    chk("R7 early reload", 32'(pulses - p0), 1);
    repeat (200) @(negedge clk);
    p0 = pulses;
    wr(4'h0, 32'h7F, 4'h1);
    repeat (2) @(negedge clk);
    chk("R7 reload inside window", 32'(pulses - p0), 0);
    wr(4'h4, 32'h7F, 4'h1);
  endtask

  task automatic t_period(input logic [1:0] psc, input int exp);
    int n;
    int m;
    int p0;
    wr(4'h4, {22'd0, 1'b1, psc, 7'h7F}, 4'h3);
    wr(4'h8, 32'h0, 4'h1);
    wr(4'h0, 32'hC3, 4'h1);
    n = 0;
    while (!early_irq && n < 2000) begin @(negedge clk); n++; end
    chk("R10 irq raised", 32'(early_irq), 1);
    p0 = pulses;
    m = 0;
    while (!wdog_rst_req && m < 2000) begin @(negedge clk); m++; end
    chk("R4 tick period", 32'(m), 32'(exp));
    @(negedge clk);
    chk("R6 one-cycle request", 32'(wdog_rst_req), 0);
    chk("R6 single request", 32'(pulses - p0), 1);
    wr(4'h8, 32'h0, 4'h1);
    chk("R10 irq cleared", 32'(early_irq), 0);
    wr(4'h0, 32'h7F, 4'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lanes();
    t_count();
    t_flag();
    t_arm();
    t_window();
    t_period(2'd0, 4);
    t_period(2'd3, 32);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule